// File: doc/BRIEF.md
# Paired-Group Register Renamer

This block renames a stream of in-order instructions in which predicated regions are built from mutually exclusive pairs. Every pair holds a leading member from the taken-if-true path and a trailing member from the taken-if-false path. Both members write the same architectural register, because the compiler pads a path with no real write using a move of a register onto itself. Only one member of a pair will ever commit, so both can share one physical destination. The block therefore keeps one mapping per architectural register and never has to merge two candidate producers.

The leading member allocates a physical register, but it leaves the mapping table untouched. The trailing member reuses that register and reads its sources from the mapping that held before the pair. The table is written once the trailing member has been renamed. Code after the region, and later pairs in the same region, see one ordinary mapping. Free physical registers sit in a bitmap pool: the lowest free index is handed out, and tags come back one at a time through a return port.

Renamed results appear one clock after an instruction is accepted. Acceptance stalls only when an allocation is needed and the pool is empty.

Top module: `pgr_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the pool holds tags NUM_ARCH to NUM_PHYS-1. Right after reset, out_valid is 0 and in_ready is 1.
- R2: An instruction outside a region (in_pred=0) with in_has_dst=1 is given the lowest-numbered free tag. The table then maps in_dst to that tag for all later readers.
- R3: A leading member (in_pred=1, in_path=1) with a destination is given the lowest-numbered free tag, and that tag leaves the pool. The table is not changed.
- R4: A trailing member (in_pred=1, in_path=0) whose in_has_dst and in_dst equal its partner's reports the partner's tag as out_dst_tag and allocates nothing.
- R5: The source tags of a trailing member come from the mapping in force before the pair started.
- R6: After a matched pair with a destination, the table maps that register to the shared tag. Later pairs in the same region and instructions after the region read that tag.
- R7: A pair whose members both have in_has_dst=0 takes nothing from the pool and leaves the table unchanged.
- R8: in_ready is 0 exactly when the presented instruction needs an allocation (a destination, and not a trailing member) and the pool is empty. A tag returned in that state raises in_ready in the next cycle.
- R9: A trailing member with no open pair, or whose destination flag or register differs from its partner's, sets out_err=1 and out_has_dst=0. It closes the open pair and leaves the table unchanged.
- R10: out_valid is 1 in the cycle after an accepted instruction (in_valid and in_ready) and 0 otherwise. out_dst_tag is 0 when out_has_dst is 0.
- R11: A tag given back on ret_valid/ret_tag rejoins the pool and can be handed out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The instruction is accepted this cycle |
| in_pred | input | 1 | Instruction lies inside a predicated region |
| in_path | input | 1 | 1 = leading (true-path) member, 0 = trailing (false-path) member |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | AW | Architectural destination |
| in_src_a | input | AW | First architectural source |
| in_src_b | input | AW | Second architectural source |
| ret_valid | input | 1 | A physical tag is returned to the pool |
| ret_tag | input | TW | Returned tag |
| out_valid | output | 1 | Renamed result valid |
| out_src_a_tag | output | TW | Physical tag of the first source |
| out_src_b_tag | output | TW | Physical tag of the second source |
| out_has_dst | output | 1 | A destination tag is reported |
| out_dst_tag | output | TW | Physical destination tag |
| out_err | output | 1 | Pairing protocol violated |

## Verification
On every cycle, the assertions check the one-cycle result timing, that a stall only happens with an empty pool, and that a matched trailing member reports exactly the tag held for its open pair. They also check that an orphan trailing member raises the error flag, that a leading member's tag has left the pool, and that pairs without a destination leave the pool alone. What sources read before and after a pair, lowest-index selection, table contents after mismatched pairs, and reuse of returned tags depend on longer histories. Only the bench's reference model shows those, through directed sequences and random streams of pairs, plain instructions and returns.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    localparam int DEF_ARCH = 16;
    localparam int DEF_PHYS = 32;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_LEAD   = 2'd1,
        KIND_FOLLOW = 2'd2
    } kind_e;

    function automatic kind_e classify(input logic in_region, input logic lead_path);
        if (!in_region) return KIND_PLAIN;
        return lead_path ? KIND_LEAD : KIND_FOLLOW;
    endfunction

    typedef struct packed {
        logic need_alloc;
        logic tbl_write;
        logic use_pend;
        logic dst_ok;
        logic err;
    } step_t;

endpackage

// File: rtl/pgr_free_pool.sv
module pgr_free_pool #(
    parameter int NPHYS = pgr_pkg::DEF_PHYS,
    parameter int NARCH = pgr_pkg::DEF_ARCH,
    localparam int TW = $clog2(NPHYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             ret_valid,
    input  logic [TW-1:0]    ret_tag,
    output logic             avail,
    output logic [TW-1:0]    grant_tag,
    output logic [NPHYS-1:0] pool_map
);
    localparam logic [NPHYS-1:0] INIT_MAP = {NPHYS{1'b1}} << NARCH;

    logic [NPHYS-1:0] pool_q;
    logic [NPHYS-1:0] pool_d;
    logic             found;

    always_comb begin
        grant_tag = '0;
        found     = 1'b0;
        for (int i = 0; i < NPHYS; i++) begin
            if (pool_q[i] && !found) begin
                grant_tag = TW'(i);
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        pool_d = pool_q;
        if (take)      pool_d[grant_tag] = 1'b0;
        if (ret_valid) pool_d[ret_tag]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pool_q <= INIT_MAP;
        else     pool_q <= pool_d;
    end

    assign avail    = found;
    assign pool_map = pool_q;
endmodule

// File: rtl/pgr_map_table.sv
module pgr_map_table #(
    parameter int NARCH = pgr_pkg::DEF_ARCH,
    parameter int NPHYS = pgr_pkg::DEF_PHYS,
    localparam int AW = $clog2(NARCH),
    localparam int TW = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output logic [TW-1:0] rd_a_tag,
    output logic [TW-1:0] rd_b_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag
);
    logic [TW-1:0] ent [NARCH];

    for (genvar g = 0; g < NARCH; g++) begin : g_ent
        logic [TW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)                                slot_q <= TW'(g);
            else if (wr_en && wr_idx == AW'(g))     slot_q <= wr_tag;
        end
        assign ent[g] = slot_q;
    end

    assign rd_a_tag = ent[rd_a_idx];
    assign rd_b_tag = ent[rd_b_idx];
endmodule

// File: rtl/pgr_pair_ctrl.sv
module pgr_pair_ctrl
    import pgr_pkg::*;
#(
    parameter int AW = 4,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          in_pred,
    input  logic          in_path,
    input  logic          in_has_dst,
    input  logic [AW-1:0] in_dst,
    input  logic [TW-1:0] grant_tag,
    output step_t         step,
    output logic [TW-1:0] dst_tag,
    output logic          pend_valid,
    output logic [TW-1:0] pend_tag,
    output logic          pend_has,
    output logic [AW-1:0] pend_dst
);
    kind_e kind;
    logic  match;

    always_comb begin
        kind  = classify(in_pred, in_path);
        match = pend_valid && (pend_has == in_has_dst) &&
                (!in_has_dst || pend_dst == in_dst);

        step.need_alloc = in_has_dst && (kind != KIND_FOLLOW);
        step.use_pend   = (kind == KIND_FOLLOW);
        step.err        = (kind == KIND_FOLLOW) && !match;
        step.dst_ok     = in_has_dst && !step.err;
        step.tbl_write  = in_has_dst &&
                          ((kind == KIND_PLAIN) || (kind == KIND_FOLLOW && match));

        if (!step.dst_ok)       dst_tag = '0;
        else if (step.use_pend) dst_tag = pend_tag;
        else                    dst_tag = grant_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_tag   <= '0;
            pend_has   <= 1'b0;
            pend_dst   <= '0;
        end else if (accept) begin
            if (kind == KIND_LEAD) begin
                pend_valid <= 1'b1;
                pend_has   <= in_has_dst;
                pend_dst   <= in_dst;
                pend_tag   <= in_has_dst ? grant_tag : '0;
            end else if (kind == KIND_FOLLOW) begin
                pend_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgr_renamer.sv
module pgr_renamer
    import pgr_pkg::*;
#(
    parameter int NUM_ARCH = pgr_pkg::DEF_ARCH,
    parameter int NUM_PHYS = pgr_pkg::DEF_PHYS,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_pred,
    input  logic          in_path,
    input  logic          in_has_dst,
    input  logic [AW-1:0] in_dst,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic          ret_valid,
    input  logic [TW-1:0] ret_tag,
    output logic          out_valid,
    output logic [TW-1:0] out_src_a_tag,
    output logic [TW-1:0] out_src_b_tag,
    output logic          out_has_dst,
    output logic [TW-1:0] out_dst_tag,
    output logic          out_err
);
    step_t            step;
    logic             accept;
    logic             pool_avail;
    logic [TW-1:0]    grant_tag;
    logic [NUM_PHYS-1:0] pool_map;
    logic [TW-1:0]    rd_a_tag;
    logic [TW-1:0]    rd_b_tag;
    logic [TW-1:0]    dst_tag;
    logic             pend_valid;
    logic [TW-1:0]    pend_tag;
    logic             pend_has;
    logic [AW-1:0]    pend_dst;

    assign in_ready = !step.need_alloc || pool_avail;
    assign accept   = in_valid && in_ready;

    pgr_pair_ctrl #(.AW(AW), .TW(TW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .in_pred    (in_pred),
        .in_path    (in_path),
        .in_has_dst (in_has_dst),
        .in_dst     (in_dst),
        .grant_tag  (grant_tag),
        .step       (step),
        .dst_tag    (dst_tag),
        .pend_valid (pend_valid),
        .pend_tag   (pend_tag),
        .pend_has   (pend_has),
        .pend_dst   (pend_dst)
    );

    pgr_free_pool #(.NPHYS(NUM_PHYS), .NARCH(NUM_ARCH)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .take      (accept && step.need_alloc),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .avail     (pool_avail),
        .grant_tag (grant_tag),
        .pool_map  (pool_map)
    );

    pgr_map_table #(.NARCH(NUM_ARCH), .NPHYS(NUM_PHYS)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (in_src_a),
        .rd_b_idx (in_src_b),
        .rd_a_tag (rd_a_tag),
        .rd_b_tag (rd_b_tag),
        .wr_en    (accept && step.tbl_write),
        .wr_idx   (in_dst),
        .wr_tag   (dst_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_src_a_tag <= '0;
            out_src_b_tag <= '0;
            out_has_dst   <= 1'b0;
            out_dst_tag   <= '0;
            out_err       <= 1'b0;
        end else begin
            out_valid <= accept;
            out_err   <= accept && step.err;
            if (accept) begin
                out_src_a_tag <= rd_a_tag;
                out_src_b_tag <= rd_b_tag;
                out_has_dst   <= step.dst_ok;
                out_dst_tag   <= dst_tag;
            end
        end
    end
endmodule

// File: rtl/pgr_renamer_chk.sv
module pgr_renamer_chk #(
    parameter int AW    = 4,
    parameter int TW    = 5,
    parameter int NPHYS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_pred,
    input logic             in_path,
    input logic             in_has_dst,
    input logic [AW-1:0]    in_dst,
    input logic             ret_valid,
    input logic             out_valid,
    input logic [TW-1:0]    out_dst_tag,
    input logic             out_has_dst,
    input logic             out_err,
    input logic             pend_valid,
    input logic [TW-1:0]    pend_tag,
    input logic             pend_has,
    input logic [AW-1:0]    pend_dst,
    input logic             pool_avail,
    input logic [NPHYS-1:0] pool_map
);
    logic acc;
    assign acc = in_valid && in_ready;

    // R10
    out_valid_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    // R10
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !out_valid);

    // R8
    stall_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |-> !pool_avail);

    // R4
    pair_share_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && in_pred && !in_path && pend_valid && pend_has && in_has_dst && in_dst == pend_dst)
        |=> (out_has_dst && out_dst_tag == $past(pend_tag)));

    // R9
    orphan_err_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && in_pred && !in_path && !pend_valid) |=> (out_err && !out_has_dst));

    // R7
    nodst_pool_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && in_pred && !in_has_dst && !ret_valid) |=> $stable(pool_map));

    // R3
    lead_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && in_pred && in_path && in_has_dst && !ret_valid) |=> !pool_map[out_dst_tag]);
endmodule

bind pgr_renamer pgr_renamer_chk #(.AW(AW), .TW(TW), .NPHYS(NUM_PHYS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_pred     (in_pred),
    .in_path     (in_path),
    .in_has_dst  (in_has_dst),
    .in_dst      (in_dst),
    .ret_valid   (ret_valid),
    .out_valid   (out_valid),
    .out_dst_tag (out_dst_tag),
    .out_has_dst (out_has_dst),
    .out_err     (out_err),
    .pend_valid  (pend_valid),
    .pend_tag    (pend_tag),
    .pend_has    (pend_has),
    .pend_dst    (pend_dst),
    .pool_avail  (pool_avail),
    .pool_map    (pool_map)
);

// File: tb/tb_pgr_renamer.sv
`timescale 1ns/1ps
module tb_pgr_renamer;
    localparam int NA = 16;
    localparam int NP = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_pred = 1'b0, in_path = 1'b0, in_has_dst = 1'b0;
    logic [3:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic       ret_valid = 1'b0;
    logic [4:0] ret_tag = '0;
    logic       in_ready, out_valid, out_has_dst, out_err;
    logic [4:0] out_src_a_tag, out_src_b_tag, out_dst_tag;

    always #2 clk = ~clk;

    pgr_renamer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pred(in_pred), .in_path(in_path), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .out_valid(out_valid),
        .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag),
        .out_has_dst(out_has_dst), .out_dst_tag(out_dst_tag), .out_err(out_err)
    );

    int n_run = 0;
    int n_fail = 0;

    // reference model
    int      m_map [NA];
    bit [NP-1:0] m_free;
    bit      m_pend;
    bit      m_pend_has;
    int      m_pend_dst;
    int      m_pend_tag;
    int      retired [$];

    function automatic int lowest_free();
        for (int i = 0; i < NP; i++) if (m_free[i]) return i;
        return -1;
    endfunction

    function automatic int free_count();
        int c = 0;
        for (int i = 0; i < NP; i++) if (m_free[i]) c++;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit pr, input bit pa, input bit hd, input int d,
                         input int sa, input int sb, input string req);
        int  e_sa, e_sb, e_dst, t;
        bit  e_hd, e_err, need, e_rdy, match;
        @(negedge clk);
        in_pred = pr; in_path = pa; in_has_dst = hd;
        in_dst = 4'(d); in_src_a = 4'(sa); in_src_b = 4'(sb);
        in_valid = 1'b1;
        #1;
        need  = hd && !(pr && !pa);
        e_rdy = !(need && free_count() == 0);
        check(in_ready == e_rdy, "R8", "in_ready", int'(in_ready), int'(e_rdy));
        if (!e_rdy) begin
            in_valid = 1'b0;
            return;
        end
        e_sa = m_map[sa]; e_sb = m_map[sb];
        e_dst = 0; e_hd = 1'b0; e_err = 1'b0;
        if (!pr) begin
            if (hd) begin
                t = lowest_free(); m_free[t] = 1'b0;
                retired.push_back(m_map[d]); m_map[d] = t;
                e_dst = t; e_hd = 1'b1;
            end
        end else if (pa) begin
            m_pend = 1'b1; m_pend_has = hd; m_pend_dst = d; m_pend_tag = 0;
            if (hd) begin
                t = lowest_free(); m_free[t] = 1'b0;
                m_pend_tag = t; e_dst = t; e_hd = 1'b1;
            end
        end else begin
            match = m_pend && (m_pend_has == hd) && (!hd || m_pend_dst == d);
            if (match) begin
                if (hd) begin
                    retired.push_back(m_map[d]); m_map[d] = m_pend_tag;
                    e_dst = m_pend_tag; e_hd = 1'b1;
                end
            end else begin
                e_err = 1'b1;
            end
            m_pend = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
        check(out_src_a_tag == 5'(e_sa) && out_src_b_tag == 5'(e_sb), req, "src tags",
              int'({out_src_a_tag, out_src_b_tag}), (e_sa << 5) | e_sb);
        check(out_has_dst == e_hd && out_dst_tag == 5'(e_dst) && out_err == e_err, req,
              "dst/err", int'({out_err, out_has_dst, out_dst_tag}),
              (int'(e_err) << 6) | (int'(e_hd) << 5) | e_dst);
        in_valid = 1'b0;
    endtask

    task automatic give_back();
        int t;
        if (retired.size() == 0) return;
        t = retired.pop_front();
        @(negedge clk);
        ret_valid = 1'b1; ret_tag = 5'(t);
        @(negedge clk);
        ret_valid = 1'b0;
        m_free[t] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int kind, d, t;
        void'($urandom(32'd4711));
        for (int i = 0; i < NA; i++) m_map[i] = i;
        m_free = {NP{1'b1}} << NA;
        m_pend = 1'b0; m_pend_has = 1'b0; m_pend_dst = 0; m_pend_tag = 0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 R10 reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        issue(0, 0, 1, 3, 5, 3, "R1");   // identity sources, dst 16 (R2)
        issue(0, 0, 0, 0, 3, 5, "R2");   // reads new mapping of r3
        issue(1, 1, 1, 7, 7, 3, "R3");   // leading member, fresh tag
        issue(1, 0, 1, 7, 7, 1, "R5");   // trailing: old r7 mapping, shared dst (R4)
        issue(1, 1, 1, 2, 7, 2, "R6");   // later pair sees r7 updated
        issue(1, 0, 1, 2, 2, 7, "R4");
        issue(0, 0, 0, 0, 2, 7, "R6");   // after region
        issue(1, 1, 0, 0, 1, 2, "R7");   // no-destination pair
        issue(1, 0, 0, 0, 1, 2, "R7");
        issue(0, 0, 1, 9, 9, 9, "R7");   // next tag unaffected by the pair
        issue(1, 0, 1, 4, 4, 4, "R9");   // orphan trailing member
        issue(1, 1, 1, 5, 5, 0, "R9");
        issue(1, 0, 1, 6, 5, 6, "R9");   // mismatched destination
        issue(0, 0, 0, 0, 6, 5, "R9");   // table unchanged by mismatch
        issue(0, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid when idle", int'(out_valid), 1'b0);

        // drain the pool, then stall (R8) and recover by a return (R11)
        while (free_count() > 0) issue(0, 0, 1, free_count() % NA, 0, 1, "R2");
        @(negedge clk);
        in_pred = 1'b0; in_has_dst = 1'b1; in_dst = 4'd4; in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1 check(in_ready == 1'b0, "R8", "stall on empty pool", int'(in_ready), 0);
            @(negedge clk);
        end
        t = retired.pop_front();
        ret_valid = 1'b1; ret_tag = 5'(t);
        #1 check(in_ready == 1'b0, "R8", "no same-cycle return bypass", int'(in_ready), 0);
        @(negedge clk);
        ret_valid = 1'b0; m_free[t] = 1'b1;
        #1 check(in_ready == 1'b1, "R8", "ready after return", int'(in_ready), 1);
        in_valid = 1'b0;
        issue(0, 0, 1, 4, 4, 0, "R11");
        check(m_map[4] == t, "R11", "returned tag reused", m_map[4], t);

        // random stream
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(1, 0) == 1 || free_count() == 0) give_back();
            kind = (free_count() == 0) ? 2 : int'($urandom_range(5, 0));
            d = int'($urandom_range(NA - 1, 0));
            case (kind)
                0: issue(0, 0, 1, d, $urandom_range(15, 0), $urandom_range(15, 0), "R2");
                1: begin
                    issue(1, 1, 1, d, $urandom_range(15, 0), $urandom_range(15, 0), "R3");
                    issue(1, 0, 1, d, $urandom_range(15, 0), $urandom_range(15, 0), "R4");
                end
                2: begin
                    issue(1, 1, 0, 0, $urandom_range(15, 0), $urandom_range(15, 0), "R7");
                    issue(1, 0, 0, 0, $urandom_range(15, 0), $urandom_range(15, 0), "R7");
                end
                3: begin
                    issue(1, 1, 1, d, $urandom_range(15, 0), $urandom_range(15, 0), "R3");
                    issue(1, 0, 1, (d + 1) % NA, d, d, "R9");
                end
                4: issue(1, 0, 1, d, d, $urandom_range(15, 0), "R9");
                default: issue(0, 0, 0, 0, $urandom_range(15, 0), d, "R6");
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule